// File: doc/BRIEF.md
# Memory Access Alignment Front Stage

This block sits at the entry of an address-translation path. It accepts one access at a time: an instruction fetch, a data read or a data write, each with an address and a size of one, two or four bytes. Two control bits decide how the access is treated. With translation switched off, the address is forwarded to memory unchanged and nothing is checked. With translation on and alignment checking on, a misaligned access is stopped at once. The block records an alignment code and the offending address in its two fault registers and answers with a fault.

An access that passes the check goes to an external translation stage through a valid/ready request. The request carries a write flag for the permission check. Fetches and data accesses follow different rules when checking is off: a fetch address is rounded down to a word boundary, while a data address is passed on unchanged. When the translation answer arrives, the block reports completion one cycle later. It raises a memory access with the physical address only if the translation reported no fault.

Top module: `mmu_align_front`

## Requirements
- R1: After reset, req_ready is 1, done, fault, mem_valid and xl_req_valid are 0, and fault_status and fault_addr are 0.
- R2: With mmu_cfg[0]=0, an accepted access raises done with fault=0 and mem_valid=1 in the next cycle. mem_addr equals req_addr unchanged even if it is misaligned and mmu_cfg[1]=1. No translation request is made.
- R3: With mmu_cfg=2'b11, a fetch (req_kind=2'b00) whose req_addr[1:0] is nonzero raises done with fault=1 in the cycle after acceptance. No translation request and no memory access are made.
- R4: With mmu_cfg=2'b01, a fetch is sent to translation with xl_addr equal to req_addr with bits [1:0] cleared.
- R5: For data accesses (req_kind 2'b01 read, 2'b10 write) with mmu_cfg=2'b11, an access faults as in R3 in two cases: size code 2'b10 (word) or 2'b11 (treated as word) with nonzero addr[1:0], and size code 2'b01 (half) with addr[0]=1. Size code 2'b00 (byte) never faults. A data address reaches xl_addr unchanged, including when it is misaligned with mmu_cfg[1]=0.
- R6: An alignment fault writes 32'h0000_0001 to fault_status and the access address to fault_addr, both visible in the done cycle. No other event changes them.
- R7: xl_is_write is 1 for data writes and 0 for fetches and data reads.
- R8: A translation answer with xl_rsp_fault=1 gives done with fault=1 in the next cycle, no mem_valid, and unchanged fault registers.
- R9: A translation answer without fault gives done with fault=0 in the next cycle. In the same cycle mem_valid=1, mem_addr=xl_rsp_pa, mem_write=1 only for data writes, and mem_size equal to the request size code. mem_valid occurs only together with done and fault=0.
- R10: req_ready is 0 from acceptance until the done cycle has passed. xl_req_valid stays 1 with a stable xl_addr until xl_req_ready is seen.
- R11: A translation answer given in the same cycle as xl_req_ready is taken, and done follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_cfg | input | 2 | Bit 0 translation enable, bit 1 alignment check enable |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 word |
| req_addr | input | 32 | Access address |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Translation stage takes the request |
| xl_addr | output | 32 | Address to translate |
| xl_is_write | output | 1 | Permission check as write |
| xl_rsp_valid | input | 1 | Translation answer valid |
| xl_rsp_fault | input | 1 | Translation or permission fault |
| xl_rsp_pa | input | 32 | Translated address |
| mem_valid | output | 1 | Memory access issued |
| mem_write | output | 1 | Memory access is a write |
| mem_size | output | 2 | Size code of the memory access |
| mem_addr | output | 32 | Memory address |
| done | output | 1 | Access finished (one cycle) |
| fault | output | 1 | Access finished with a fault |
| fault_status | output | 32 | Fault status register |
| fault_addr | output | 32 | Fault address register |

## Verification
The translation grant and the translation answer can fall in the same cycle. When they do, the block must leave its request state and take the answer at once. It must neither wait for a second answer nor drop this one. The bench's translation model asserts both in one cycle for some accesses, with and without a fault. It judges the result by the done cycle, the fault flag and the memory address. A stalled grant is also provoked, to confirm that the request is held steady until it is taken.

// File: rtl/mmu_align_pkg.sv
package mmu_align_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_XREQ  = 2'b01,
    ST_XWAIT = 2'b10,
    ST_RESP  = 2'b11
  } ctl_state_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_CHK_BIT = 1;
  localparam logic [3:0] FSR_ALIGN_CODE = 4'b0001;

  function automatic logic kind_is_fetch(acc_kind_e k);
    return k == ACC_FETCH;
  endfunction

  function automatic logic kind_is_write(acc_kind_e k);
    return k == ACC_WRITE;
  endfunction

endpackage

// File: rtl/mmu_align_rule.sv
module mmu_align_rule
  import mmu_align_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  acc_kind_e         kind,
  input  acc_size_e         size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chk_en,
  output logic              misaligned,
  output logic [ADDR_W-1:0] adj_addr
);

  localparam int LOW_W   = $clog2(WORD_BYTES);
  localparam int N_SIZES = 4;

  logic [LOW_W-1:0] size_mask [N_SIZES];
  logic [LOW_W-1:0] low_bits;
  logic [LOW_W-1:0] sel_mask;
  logic             data_bad;
  logic             fetch_bad;

  // Mask of address bits that must be zero for each size code; codes
  // wider than a word are clipped to the word mask.
  genvar gi;
  generate
    for (gi = 0; gi < N_SIZES; gi++) begin : g_size
      localparam int RAW = (1 << gi) - 1;
      assign size_mask[gi] = LOW_W'(RAW) & {LOW_W{1'b1}};
    end
  endgenerate

  assign low_bits  = addr[LOW_W-1:0];
  assign sel_mask  = size_mask[size];
  assign data_bad  = |(low_bits & sel_mask);
  assign fetch_bad = |low_bits;

  always_comb begin
    if (kind_is_fetch(kind)) begin
      misaligned = chk_en & fetch_bad;
      adj_addr   = {addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
    end else begin
      misaligned = chk_en & data_bad;
      adj_addr   = addr;
    end
  end

endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FSR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_en,
  input  logic [ADDR_W-1:0] log_addr,
  output logic [FSR_W-1:0]  fault_status,
  output logic [ADDR_W-1:0] fault_addr
);

  logic [FSR_W-1:0]  fsr_d, fsr_q;
  logic [ADDR_W-1:0] far_d, far_q;

  always_comb begin
    fsr_d = fsr_q;
    far_d = far_q;
    if (log_en) begin
      fsr_d = {{(FSR_W-4){1'b0}}, FSR_ALIGN_CODE};
      far_d = log_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (log_en) begin
      fsr_q <= fsr_d;
      far_q <= far_d;
    end
  end

  assign fault_status = fsr_q;
  assign fault_addr   = far_q;

endmodule

// File: rtl/mmu_access_ctrl.sv
module mmu_access_ctrl
  import mmu_align_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  acc_kind_e         req_kind,
  input  acc_size_e         req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mmu_en,
  input  logic              misaligned,
  input  logic [ADDR_W-1:0] adj_addr,
  output logic              req_ready,
  output logic              xl_req_valid,
  input  logic              xl_req_ready,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_is_write,
  input  logic              xl_rsp_valid,
  input  logic              xl_rsp_fault,
  input  logic [ADDR_W-1:0] xl_rsp_pa,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              fault,
  output logic              log_en,
  output logic              rsp_take
);

  ctl_state_e        state_d, state_q;
  acc_kind_e         kind_d, kind_q;
  acc_size_e         size_d, size_q;
  logic [ADDR_W-1:0] addr_d, addr_q;
  logic              fault_d, fault_q;
  logic              accept;
  logic              info_en;
  logic              addr_en;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign info_en = accept;
  assign addr_en = accept | rsp_take;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    size_d   = size_q;
    addr_d   = addr_q;
    fault_d  = fault_q;
    log_en   = 1'b0;
    rsp_take = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          kind_d = req_kind;
          size_d = req_size;
          if (!mmu_en) begin
            addr_d  = req_addr;
            fault_d = 1'b0;
            state_d = ST_RESP;
          end else if (misaligned) begin
            addr_d  = req_addr;
            fault_d = 1'b1;
            log_en  = 1'b1;
            state_d = ST_RESP;
          end else begin
            addr_d  = adj_addr;
            fault_d = 1'b0;
            state_d = ST_XREQ;
          end
        end
      end
      ST_XREQ: begin
        if (xl_req_ready) begin
          if (xl_rsp_valid) begin
            rsp_take = 1'b1;
            addr_d   = xl_rsp_pa;
            fault_d  = xl_rsp_fault;
            state_d  = ST_RESP;
          end else begin
            state_d = ST_XWAIT;
          end
        end
      end
      ST_XWAIT: begin
        if (xl_rsp_valid) begin
          rsp_take = 1'b1;
          addr_d   = xl_rsp_pa;
          fault_d  = xl_rsp_fault;
          state_d  = ST_RESP;
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_FETCH;
      size_q <= SZ_BYTE;
    end else if (info_en) begin
      kind_q <= kind_d;
      size_q <= size_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      fault_q <= 1'b0;
    end else if (addr_en) begin
      addr_q  <= addr_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign xl_req_valid = (state_q == ST_XREQ);
  assign xl_addr      = addr_q;
  assign xl_is_write  = kind_is_write(kind_q);
  assign done         = (state_q == ST_RESP);
  assign fault        = done & fault_q;
  assign mem_valid    = done & ~fault_q;
  assign mem_write    = kind_is_write(kind_q);
  assign mem_size     = size_q;
  assign mem_addr     = addr_q;

endmodule

// File: rtl/mmu_align_front.sv
module mmu_align_front
  import mmu_align_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FSR_W      = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mmu_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              xl_req_valid,
  input  logic              xl_req_ready,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              xl_is_write,
  input  logic              xl_rsp_valid,
  input  logic              xl_rsp_fault,
  input  logic [ADDR_W-1:0] xl_rsp_pa,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              done,
  output logic              fault,
  output logic [FSR_W-1:0]  fault_status,
  output logic [ADDR_W-1:0] fault_addr
);

  acc_kind_e         kind_in;
  acc_size_e         size_in;
  logic              misaligned;
  logic [ADDR_W-1:0] adj_addr;
  logic              log_en;
  logic              rsp_take;

  assign kind_in = acc_kind_e'(req_kind);
  assign size_in = acc_size_e'(req_size);

  mmu_align_rule #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_rule (
    .kind      (kind_in),
    .size      (size_in),
    .addr      (req_addr),
    .chk_en    (mmu_cfg[CFG_CHK_BIT]),
    .misaligned(misaligned),
    .adj_addr  (adj_addr)
  );

  mmu_access_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_kind    (kind_in),
    .req_size    (size_in),
    .req_addr    (req_addr),
    .mmu_en      (mmu_cfg[CFG_EN_BIT]),
    .misaligned  (misaligned),
    .adj_addr    (adj_addr),
    .req_ready   (req_ready),
    .xl_req_valid(xl_req_valid),
    .xl_req_ready(xl_req_ready),
    .xl_addr     (xl_addr),
    .xl_is_write (xl_is_write),
    .xl_rsp_valid(xl_rsp_valid),
    .xl_rsp_fault(xl_rsp_fault),
    .xl_rsp_pa   (xl_rsp_pa),
    .mem_valid   (mem_valid),
    .mem_write   (mem_write),
    .mem_size    (mem_size),
    .mem_addr    (mem_addr),
    .done        (done),
    .fault       (fault),
    .log_en      (log_en),
    .rsp_take    (rsp_take)
  );

  mmu_fault_log #(
    .ADDR_W(ADDR_W),
    .FSR_W (FSR_W)
  ) u_log (
    .clk         (clk),
    .rst_n       (rst_n),
    .log_en      (log_en),
    .log_addr    (req_addr),
    .fault_status(fault_status),
    .fault_addr  (fault_addr)
  );

endmodule

// File: rtl/mmu_align_front_chk.sv
module mmu_align_front_chk #(
  parameter int ADDR_W = 32,
  parameter int FSR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mmu_cfg,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              xl_req_valid,
  input logic              xl_req_ready,
  input logic [ADDR_W-1:0] xl_addr,
  input logic              xl_rsp_fault,
  input logic [ADDR_W-1:0] xl_rsp_pa,
  input logic              rsp_take,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              done,
  input logic              fault,
  input logic [FSR_W-1:0]  fault_status,
  input logic [ADDR_W-1:0] fault_addr
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready); // R10

  AST_XREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_valid && !xl_req_ready) |=> (xl_req_valid && $stable(xl_addr))); // R10

  AST_MMU_OFF_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !mmu_cfg[0]) |=> (done && !fault && mem_valid && !xl_req_valid
                              && mem_addr == $past(req_addr))); // R2

  AST_FETCH_ALIGN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mmu_cfg == 2'b11 && req_kind == 2'b00 && req_addr[1:0] != 2'b00)
    |=> (done && fault && !xl_req_valid && fault_status == 32'h1
         && fault_addr == $past(req_addr))); // R3

  AST_FETCH_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mmu_cfg == 2'b01 && req_kind == 2'b00)
    |=> (xl_req_valid && xl_addr[1:0] == 2'b00)); // R4

  AST_BYTE_NEVER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mmu_cfg[0] && req_kind != 2'b00 && req_size == 2'b00)
    |=> (xl_req_valid && xl_addr == $past(req_addr))); // R5

  AST_XLAT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> (done && fault == $past(xl_rsp_fault) && $stable(fault_status)
                  && $stable(fault_addr))); // R8

  AST_XLAT_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !xl_rsp_fault) |=> (mem_valid && mem_addr == $past(xl_rsp_pa))); // R9

  AST_MEM_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (done && !fault)); // R9

endmodule

bind mmu_align_front mmu_align_front_chk #(
  .ADDR_W(ADDR_W),
  .FSR_W (FSR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mmu_cfg     (mmu_cfg),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_kind    (req_kind),
  .req_size    (req_size),
  .req_addr    (req_addr),
  .xl_req_valid(xl_req_valid),
  .xl_req_ready(xl_req_ready),
  .xl_addr     (xl_addr),
  .xl_rsp_fault(xl_rsp_fault),
  .xl_rsp_pa   (xl_rsp_pa),
  .rsp_take    (rsp_take),
  .mem_valid   (mem_valid),
  .mem_addr    (mem_addr),
  .done        (done),
  .fault       (fault),
  .fault_status(fault_status),
  .fault_addr  (fault_addr)
);

// File: tb/mmu_align_front_tb.sv
`timescale 1ns/1ps
module mmu_align_front_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mmu_cfg;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_kind;
  logic [1:0]  req_size;
  logic [31:0] req_addr;
  logic        xl_req_valid;
  logic        xl_req_ready;
  logic [31:0] xl_addr;
  logic        xl_is_write;
  logic        xl_rsp_valid;
  logic        xl_rsp_fault;
  logic [31:0] xl_rsp_pa;
  logic        mem_valid;
  logic        mem_write;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr;
  logic        done;
  logic        fault;
  logic [31:0] fault_status;
  logic [31:0] fault_addr;

  mmu_align_front u_dut (.*);

  typedef struct {
    string       tag;
    logic        fault;
    logic        mem;
    logic [31:0] mem_addr;
    logic        mem_write;
    logic [1:0]  mem_size;
    logic [31:0] fsr;
    logic [31:0] far;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  int          done_cnt = 0;
  bit          finished = 0;
  logic [31:0] exp_fsr = 0;
  logic [31:0] exp_far = 0;

  // translation model controls
  int          cfg_hold = 0;
  bit          cfg_zero = 0;
  bit          cfg_tfault = 0;
  logic [31:0] cfg_pa = 0;
  bit          xl_seen = 0;
  logic [31:0] seen_addr = 0;
  logic        seen_wr = 0;

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // translation stage model
  initial begin
    xl_req_ready = 0; xl_rsp_valid = 0; xl_rsp_fault = 0; xl_rsp_pa = 0;
    forever begin
      @(negedge clk);
      xl_req_ready = 0;
      xl_rsp_valid = 0;
      if (rst_n && xl_req_valid) begin
        xl_seen = 1; seen_addr = xl_addr; seen_wr = xl_is_write;
        for (int i = 0; i < cfg_hold; i++) begin
          @(negedge clk);
          check("R10 request held", {31'd0, xl_req_valid}, 32'd1);
          check("R10 address stable", xl_addr, seen_addr);
        end
        xl_req_ready = 1; xl_rsp_fault = cfg_tfault; xl_rsp_pa = cfg_pa;
        if (cfg_zero) xl_rsp_valid = 1;
        else begin
          @(negedge clk); xl_req_ready = 0;
          @(negedge clk); xl_rsp_valid = 1;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_valid && !done) check("R9 mem_valid outside done", 32'd1, 32'd0);
        if (done) begin
          if (sb_q.size() == 0) begin
            check("R9 unexpected done", 32'd1, 32'd0);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " fault"}, {31'd0, fault}, {31'd0, e.fault});
            check({e.tag, " mem_valid"}, {31'd0, mem_valid}, {31'd0, e.mem});
            if (e.mem) begin
              check({e.tag, " mem_addr"}, mem_addr, e.mem_addr);
              check({e.tag, " mem_write"}, {31'd0, mem_write}, {31'd0, e.mem_write});
              check({e.tag, " mem_size"}, {30'd0, mem_size}, {30'd0, e.mem_size});
            end
            check({e.tag, " R6 fault_status"}, fault_status, e.fsr);
            check({e.tag, " R6 fault_addr"}, fault_addr, e.far);
          end
          done_cnt++;
        end
      end
    end
  end

  // driver: computes expectation from the requirements, pushes it, drives
  task automatic access(string tag, logic [1:0] cfg, logic [1:0] kind,
                        logic [1:0] size, logic [31:0] addr, bit tfault,
                        logic [31:0] pa, bit zero, int hold);
    exp_t e;
    bit   en, chk, mis, xl_exp;
    logic [31:0] xl_a;
    int   c0;
    en  = cfg[0];
    chk = cfg[1];
    if (kind == 2'b00) mis = chk && (addr[1:0] != 0);
    else if (size == 2'b01) mis = chk && addr[0];
    else if (size == 2'b00) mis = 0;
    else mis = chk && (addr[1:0] != 0);
    e.tag = tag; e.mem_write = (kind == 2'b10); e.mem_size = size;
    xl_exp = 0; xl_a = 0;
    if (!en) begin
      e.fault = 0; e.mem = 1; e.mem_addr = addr;
    end else if (mis) begin
      e.fault = 1; e.mem = 0; e.mem_addr = 0;
      exp_fsr = 32'h1; exp_far = addr;
    end else begin
      xl_exp = 1;
      xl_a = (kind == 2'b00) ? {addr[31:2], 2'b00} : addr;
      e.fault = tfault; e.mem = !tfault; e.mem_addr = pa;
    end
    e.fsr = exp_fsr; e.far = exp_far;
    sb_q.push_back(e);
    cfg_tfault = tfault; cfg_pa = pa; cfg_zero = zero; cfg_hold = hold;
    xl_seen = 0;
    c0 = done_cnt;
    @(negedge clk);
    mmu_cfg = cfg; req_kind = kind; req_size = size; req_addr = addr;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check({tag, " R10 ready low after accept"}, {31'd0, req_ready}, 32'd0);
    wait (done_cnt != c0);
    @(negedge clk);
    check({tag, " translation requested"}, {31'd0, xl_seen}, {31'd0, xl_exp});
    if (xl_exp && xl_seen) begin
      check({tag, " xl_addr"}, seen_addr, xl_a);
      check({tag, " R7 xl_is_write"}, {31'd0, seen_wr}, {31'd0, (kind == 2'b10)});
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 0; mmu_cfg = 0; req_valid = 0; req_kind = 0; req_size = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
    check("R1 xl_req_valid", {31'd0, xl_req_valid}, 32'd0);
    check("R1 fault_status", fault_status, 32'd0);
    check("R1 fault_addr", fault_addr, 32'd0);

    access("R2 off misaligned", 2'b10, 2'b01, 2'b10, 32'h0000_1003, 0, 0, 0, 0);
    access("R3 fetch fault", 2'b11, 2'b00, 2'b10, 32'h0000_2002, 0, 0, 0, 0);
    access("R4 fetch round", 2'b01, 2'b00, 2'b10, 32'h0000_3007, 0, 32'h8000_3004, 0, 0);
    access("R5 word read fault", 2'b11, 2'b01, 2'b10, 32'h0000_4001, 0, 0, 0, 0);
    access("R5 half write fault", 2'b11, 2'b10, 2'b01, 32'h0000_5001, 0, 0, 0, 0);
    access("R7 half write ok", 2'b11, 2'b10, 2'b01, 32'h0000_5002, 0, 32'h9000_5002, 0, 0);
    access("R5 byte never faults", 2'b11, 2'b01, 2'b00, 32'h0000_6003, 0, 32'h9000_6003, 0, 0);
    access("R5 data unchanged", 2'b01, 2'b01, 2'b10, 32'h0000_7002, 0, 32'h9000_7002, 0, 0);
    access("R8 translation fault", 2'b11, 2'b10, 2'b10, 32'h0000_8000, 1, 32'h9000_8000, 0, 0);
    access("R11 same-cycle ok", 2'b11, 2'b01, 2'b10, 32'h0000_a004, 0, 32'h9000_a004, 1, 0);
    access("R11 same-cycle fault", 2'b11, 2'b10, 2'b00, 32'h0000_b001, 1, 32'h9000_b001, 1, 0);
    access("R10 stalled grant", 2'b11, 2'b00, 2'b10, 32'h0000_c008, 0, 32'h9000_c008, 0, 3);
    access("R5 wide size code", 2'b11, 2'b01, 2'b11, 32'h0000_d002, 0, 0, 0, 0);
    access("R9 write ok", 2'b01, 2'b10, 2'b10, 32'h0000_e000, 0, 32'h9000_e000, 0, 1);

    repeat (3) @(negedge clk);
    check("R9 scoreboard drained", sb_q.size(), 32'd0);
    report();
  end

endmodule